// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an internal valid/ready request bus and an external asynchronous static RAM with an 18-bit word address, a 16-bit data bus and active-low chip-select, write-strobe, output-enable and per-byte-lane strobes. Each accepted request becomes a fixed sequence of clocked phases. The address is set up first with every strobe high. The strobes are then held low for a number of cycles set by a parameter. The sequence ends with a recovery gap. This keeps every access within the RAM's minimum timing without any asynchronous logic.

Reads hand back one 16-bit word with a single-cycle `rd_valid` pulse. Lanes that were not requested read as zero. Writes honour a two-bit lane mask. The controller's data driver stays off at the start of the write pulse, so the RAM's own output drivers have time to go high impedance before the controller drives the bus. A request whose mask is zero finishes without touching the RAM.

The data bus is split at this boundary into a driven value, a drive enable and a received value. The pad ring joins them into the bidirectional pins.

Top module: `xsram_ctl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken at the clock edge where `req_valid` and `req_ready` are both high. From the next cycle `req_ready` stays low until the access and its recovery gap are over.
- R2: `ram_addr` changes only on an edge where chip-select, write strobe, output enable and both lane strobes are high, both before and after that edge.
- R3: A read holds chip-select, output enable and the requested lane strobes low, with the write strobe high, for exactly `RD_CYC` cycles (at least 55 ns). `rd_valid` rises on the `RD_CYC`+1-th clock edge after the accepting edge.
- R4: A write holds chip-select, write strobe and the requested lane strobes low, with output enable high, for `WR_CYC` cycles (at least 45 ns). The address is stable for at least 50 ns when the write strobe rises.
- R5: `ram_dq_oe` is high only while the write strobe is low and output enable is high. It stays low for the first `TURN_CYC` cycles of the pulse (at least 20 ns). It then stays high until the write strobe rises, for at least 25 ns.
- R6: Lane strobe bit 0 follows `req_mask[0]` and gates data bits 7..0. Lane strobe bit 1 follows `req_mask[1]` and gates bits 15..8. A lane strobe is low during an access exactly when its mask bit is 1. Chip-select is low exactly when at least one lane strobe is low.
- R7: In `rd_data`, a lane whose mask bit is 0 is zero. A selected lane carries the RAM's value from the last cycle of the strobe window. `rd_valid` is high for one cycle per read.
- R8: A write changes only the requested lanes of the addressed word. The other lane keeps its earlier content.
- R9: A request with mask 0 never pulls chip-select low. For a read with mask 0, `rd_valid` rises with all-zero data on the accepting edge itself.
- R10: Between two RAM accesses, every strobe stays high for at least `REC_CYC`+2 cycles.
- R11: During and after reset, all strobes are high, `ram_dq_oe` and `rd_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | 2 | Byte-lane enables, bit 0 = bits 7..0 |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read response strobe |
| rd_data | output | 16 | Read data, unselected lanes zero |
| ram_addr | output | 18 | RAM address pins |
| ram_dq_o | output | 16 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Data driver enable |
| ram_dq_i | input | 16 | Data received from the RAM |
| ram_ce_n | output | 1 | Chip-select, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_lane_n | output | 2 | Byte-lane strobes, active low, bit 0 = low byte |

## Verification
On one clock edge a read both captures its data and releases output enable. The bench's RAM model drives a lane only while output enable and that lane's strobe are low, and it drives a filler value at all other times. A capture one edge late therefore returns the filler value and fails the comparison against the bench's shadow memory. On one edge a write also turns its driver off and raises the write strobe. The model stores a lane at every falling clock edge of the overlap and stores a marker value whenever the driver is off. A driver that turns off early, or late, shows up on the next read-back of that word.

// File: rtl/xsram_pkg.sv
// Shared types for the static RAM access controller.
package xsram_pkg;

    // Phase of the access sequencer.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_SETUP = 3'd1,
        ST_RD_WAIT  = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_RECOVER  = 3'd5
    } seq_state_e;

    // Largest of three cycle counts, used to size the phase counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/xsram_seq.sv
// Access sequencer: walks each accepted request through setup, strobe and
// recovery phases. It emits the strobe levels for the next cycle, the
// driver enable and a capture pulse.
// Assumes: RD_CYC, WR_CYC, REC_CYC >= 1 and TURN_CYC < WR_CYC.
module xsram_seq
    import xsram_pkg::*;
#(
    parameter int LANES    = 2,
    parameter int RD_CYC   = 7,
    parameter int WR_CYC   = 7,
    parameter int TURN_CYC = 3,
    parameter int REC_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LANES-1:0] req_mask,
    output logic             req_ready,
    output logic             accept,
    output logic             nxt_ce_n,
    output logic             nxt_oe_n,
    output logic             nxt_we_n,
    output logic [LANES-1:0] nxt_lane_n,
    output logic             nxt_drive,
    output logic             cap_en,
    output logic [LANES-1:0] cap_mask
);

    localparam int MAX_CYC  = max3(RD_CYC, WR_CYC, REC_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam int DRV_FROM = WR_CYC - 1 - TURN_CYC;

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [LANES-1:0] mask_q;
    logic             strobe_on;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign cap_mask  = (state_q == ST_IDLE) ? req_mask : mask_q;

    // Next phase, counter value and capture decision.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cap_en  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_mask == '0) begin
                        state_d = ST_RECOVER;
                        cnt_d   = CNT_W'(REC_CYC - 1);
                        cap_en  = !req_write;
                    end else begin
                        state_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
                    end
                end
            end
            ST_RD_SETUP: begin
                state_d = ST_RD_WAIT;
                cnt_d   = CNT_W'(RD_CYC - 1);
            end
            ST_RD_WAIT: begin
                if (cnt_q == '0) begin
                    cap_en  = 1'b1;
                    state_d = ST_RECOVER;
                    cnt_d   = CNT_W'(REC_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WR_SETUP: begin
                state_d = ST_WR_PULSE;
                cnt_d   = CNT_W'(WR_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (cnt_q == '0) begin
                    state_d = ST_RECOVER;
                    cnt_d   = CNT_W'(REC_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_RECOVER: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Strobe and driver levels the pads take on the coming edge.
    always_comb begin
        strobe_on  = (state_d == ST_RD_WAIT) || (state_d == ST_WR_PULSE);
        nxt_ce_n   = !strobe_on;
        nxt_oe_n   = (state_d != ST_RD_WAIT);
        nxt_we_n   = (state_d != ST_WR_PULSE);
        nxt_lane_n = strobe_on ? ~mask_q : '1;
        nxt_drive  = (state_d == ST_WR_PULSE) && (int'(cnt_d) <= DRV_FROM);
    end

    // Phase, counter and latched lane mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) mask_q <= req_mask;
        end
    end

endmodule

// File: rtl/xsram_pads.sv
// Pad register stage: every RAM-facing output comes straight from a flop,
// so the pins never glitch. Address and write data load only on acceptance,
// which happens while all strobes are high.
module xsram_pads #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              nxt_ce_n,
    input  logic              nxt_oe_n,
    input  logic              nxt_we_n,
    input  logic [LANES-1:0]  nxt_lane_n,
    input  logic              nxt_drive,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_o,
    output logic              ram_dq_oe,
    output logic              ram_ce_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [LANES-1:0]  ram_lane_n
);

    // Address and outbound data, held for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr <= '0;
            ram_dq_o <= '0;
        end else if (accept) begin
            ram_addr <= req_addr;
            ram_dq_o <= req_wdata;
        end
    end

    // Strobes and driver enable, inactive out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_ce_n   <= 1'b1;
            ram_oe_n   <= 1'b1;
            ram_we_n   <= 1'b1;
            ram_lane_n <= '1;
            ram_dq_oe  <= 1'b0;
        end else begin
            ram_ce_n   <= nxt_ce_n;
            ram_oe_n   <= nxt_oe_n;
            ram_we_n   <= nxt_we_n;
            ram_lane_n <= nxt_lane_n;
            ram_dq_oe  <= nxt_drive;
        end
    end

endmodule

// File: rtl/xsram_rdcap.sv
// Read capture: on a capture pulse it registers the received bus one lane
// at a time and forces unrequested lanes to zero. It raises the response
// strobe for one cycle.
// Assumes: DATA_W is LANES * 8.
module xsram_rdcap #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [LANES-1:0]  cap_mask,
    input  logic [DATA_W-1:0] ram_dq_i,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    // Response strobe follows the capture pulse by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= cap_en;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per-lane data register, zero when the lane was not requested.
        always_ff @(posedge clk) begin
            if (!rst_n)      rd_data[g*8 +: 8] <= '0;
            else if (cap_en) rd_data[g*8 +: 8] <= cap_mask[g] ? ram_dq_i[g*8 +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/xsram_ctl.sv
// Top of the static RAM access controller: valid/ready requests in, clocked
// strobe sequences out. The cycle counts must cover the RAM's minimum
// timing at the clock period in use. CLK_NS is only used by the checker.
module xsram_ctl #(
    parameter int  ADDR_W   = 18,
    parameter int  DATA_W   = 16,
    parameter int  CLK_NS   = 8,
    parameter int  RD_CYC   = 7,
    parameter int  WR_CYC   = 7,
    parameter int  TURN_CYC = 3,
    parameter int  REC_CYC  = 1,
    localparam int LANES    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [LANES-1:0]  req_mask,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_o,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_i,
    output logic              ram_ce_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [LANES-1:0]  ram_lane_n
);

    logic             accept;
    logic             nxt_ce_n, nxt_oe_n, nxt_we_n, nxt_drive, cap_en;
    logic [LANES-1:0] nxt_lane_n, cap_mask;

    xsram_seq #(
        .LANES(LANES), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC),
        .TURN_CYC(TURN_CYC), .REC_CYC(REC_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_mask(req_mask),
        .req_ready(req_ready), .accept(accept),
        .nxt_ce_n(nxt_ce_n), .nxt_oe_n(nxt_oe_n), .nxt_we_n(nxt_we_n),
        .nxt_lane_n(nxt_lane_n), .nxt_drive(nxt_drive),
        .cap_en(cap_en), .cap_mask(cap_mask)
    );

    xsram_pads #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_pads (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .nxt_ce_n(nxt_ce_n), .nxt_oe_n(nxt_oe_n), .nxt_we_n(nxt_we_n),
        .nxt_lane_n(nxt_lane_n), .nxt_drive(nxt_drive),
        .ram_addr(ram_addr), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe),
        .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
        .ram_lane_n(ram_lane_n)
    );

    xsram_rdcap #(.DATA_W(DATA_W), .LANES(LANES)) u_rdcap (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_mask(cap_mask),
        .ram_dq_i(ram_dq_i), .rd_valid(rd_valid), .rd_data(rd_data)
    );

endmodule

// File: rtl/xsram_ctl_chk.sv
// Protocol checker for xsram_ctl, attached by bind. It measures strobe
// windows in cycles and compares them, scaled by the clock period, against
// the RAM's minimum times in nanoseconds.
module xsram_ctl_chk #(
    parameter int  ADDR_W      = 18,
    parameter int  DATA_W      = 16,
    parameter int  CLK_NS      = 8,
    parameter int  RD_CYC      = 7,
    parameter int  RD_MIN_NS   = 55,
    parameter int  WP_MIN_NS   = 45,
    parameter int  AW_MIN_NS   = 50,
    parameter int  DS_MIN_NS   = 25,
    parameter int  TURN_MIN_NS = 20,
    localparam int LANES       = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_dq_oe,
    input logic              ram_ce_n,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic [LANES-1:0]  ram_lane_n
);

    logic              all_hi;
    logic [ADDR_W-1:0] addr_prev;
    int unsigned       oe_lo_cnt, we_lo_cnt, pre_cnt, drv_cnt, addr_age;

    assign all_hi = ram_ce_n && ram_oe_n && ram_we_n && (&ram_lane_n);

    // Window counters measured at the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_lo_cnt <= 0;
            we_lo_cnt <= 0;
            pre_cnt   <= 0;
            drv_cnt   <= 0;
            addr_age  <= 0;
            addr_prev <= '0;
        end else begin
            oe_lo_cnt <= ram_oe_n ? 0 : oe_lo_cnt + 1;
            we_lo_cnt <= ram_we_n ? 0 : we_lo_cnt + 1;
            if (ram_we_n)        pre_cnt <= 0;
            else if (!ram_dq_oe) pre_cnt <= pre_cnt + 1;
            drv_cnt   <= ram_dq_oe ? drv_cnt + 1 : 0;
            addr_prev <= ram_addr;
            if (ram_addr != addr_prev) addr_age <= 1;
            else if (addr_age < 32'hFFFF) addr_age <= addr_age + 1;
        end
    end

    a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_addr != $past(ram_addr)) |-> (all_hi && $past(all_hi)));

    a_r3_read_shape: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> (!ram_ce_n && ram_we_n));

    a_r3_read_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_oe_n) |-> (oe_lo_cnt == RD_CYC && oe_lo_cnt * CLK_NS >= RD_MIN_NS));

    a_r4_write_shape: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_ce_n && ram_oe_n));

    a_r4_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (we_lo_cnt * CLK_NS >= WP_MIN_NS && (addr_age + 1) * CLK_NS >= AW_MIN_NS));

    a_r5_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> (!ram_we_n && ram_oe_n));

    a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_dq_oe) |-> (pre_cnt * CLK_NS >= TURN_MIN_NS));

    a_r5_data_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (drv_cnt * CLK_NS >= DS_MIN_NS && $past(ram_dq_oe)));

    a_r6_lanes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce_n |-> (&ram_lane_n));

    a_r6_lane_active: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_ce_n |-> !(&ram_lane_n));

    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_ce_n) |=> all_hi);

endmodule

bind xsram_ctl xsram_ctl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS), .RD_CYC(RD_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rd_valid(rd_valid), .ram_addr(ram_addr), .ram_dq_oe(ram_dq_oe),
    .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_lane_n(ram_lane_n)
);

// File: tb/xsram_ctl_tb.sv
// Self-checking bench: a behavioural RAM on the pad side, a shadow memory
// for expected values, directed corner cases and then seeded random traffic.
module xsram_ctl_tb;

    localparam int AW = 18, DW = 16, RD = 7, WR = 7, TURN = 3, REC = 1;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]    req_mask = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rd_valid, ram_dq_oe, ram_ce_n, ram_oe_n, ram_we_n;
    logic [DW-1:0] rd_data, ram_dq_o, ram_dq_i = '0;
    logic [AW-1:0] ram_addr;
    logic [1:0]    ram_lane_n;

    int checks = 0, errors = 0;
    logic [DW-1:0] ram_mem [logic [AW-1:0]];
    logic [DW-1:0] shadow  [logic [AW-1:0]];
    logic [1:0]    mask_q [$];
    logic [1:0]    mon_mask = '0;
    int  ce_low_cnt = 0, contention = 0, lane_bad = 0, hi_run = 0, min_gap = 1000;
    bit  seen_access = 1'b0;

    always #4 clk = ~clk;

    xsram_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(8), .RD_CYC(RD),
                .WR_CYC(WR), .TURN_CYC(TURN), .REC_CYC(REC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_mask(req_mask), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .ram_addr(ram_addr), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe),
        .ram_dq_i(ram_dq_i), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n), .ram_lane_n(ram_lane_n));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
        return shadow.exists(a) ? shadow[a] : '0;
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a, input logic [1:0] m);
        logic [DW-1:0] v = peek(a);
        return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                            input logic [1:0] m);
        return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
    endfunction

    // Behavioural RAM and pin monitors, evaluated away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ram_ce_n && !ram_we_n) begin
                logic [DW-1:0] cur;
                cur = ram_mem.exists(ram_addr) ? ram_mem[ram_addr] : '0;
                for (int l = 0; l < 2; l++)
                    if (!ram_lane_n[l]) cur[l*8 +: 8] = ram_dq_oe ? ram_dq_o[l*8 +: 8] : 8'hEE;
                ram_mem[ram_addr] = cur;
            end
            for (int l = 0; l < 2; l++) begin
                if (!ram_ce_n && !ram_oe_n && ram_we_n && !ram_lane_n[l])
                    ram_dq_i[l*8 +: 8] <= ram_mem.exists(ram_addr) ? ram_mem[ram_addr][l*8 +: 8] : 8'h00;
                else
                    ram_dq_i[l*8 +: 8] <= 8'hA5;
            end
            if (ram_dq_oe && !ram_oe_n) contention++;
            if (!ram_ce_n) begin
                if (hi_run != 0) begin
                    if (seen_access && hi_run < min_gap) min_gap = hi_run;
                    seen_access = 1'b1;
                    if (mask_q.size() > 0) mon_mask = mask_q.pop_front();
                end
                hi_run = 0;
                ce_low_cnt++;
                if (ram_lane_n !== ~mon_mask) lane_bad++;
            end else begin
                hi_run++;
            end
        end
    end

    // Issue one request and return on the first falling edge after its acceptance.
    task automatic issue(input bit wr, input logic [1:0] m, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_mask = m; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (m != 2'b00) mask_q.push_back(m);
        @(negedge clk);
        req_valid = 1'b0;
        if (m != 2'b00) check(!req_ready, "R1", "ready low after accept", req_ready, 0);
    endtask

    task automatic do_write(input logic [1:0] m, input logic [AW-1:0] a, input logic [DW-1:0] d);
        shadow[a] = merge(peek(a), d, m);
        issue(1'b1, m, a, d);
    endtask

    task automatic do_read(input logic [1:0] m, input logic [AW-1:0] a);
        int n = 1;
        logic [DW-1:0] e = exp_read(a, m);
        issue(1'b0, m, a, '0);
        while (!rd_valid && n < 100) begin @(negedge clk); n++; end
        if (m == 2'b00) begin
            check(n == 1, "R9", "zero-mask read latency", n, 1);
            check(rd_data == 16'h0, "R9", "zero-mask read data", rd_data, 0);
        end else begin
            check(n == RD + 2, "R3", "read latency", n, RD + 2);
            check(rd_data == e, "R7", "read data", rd_data, e);
        end
        @(negedge clk);
        check(!rd_valid, "R7", "valid single cycle", rd_valid, 0);
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        finish_run();
    end

    initial begin : main
        int ce0;
        logic [AW-1:0] pool [12];
        repeat (4) @(negedge clk);
        // R11: reset state, sampled while reset is still held.
        check(ram_ce_n && ram_oe_n && ram_we_n && ram_lane_n == 2'b11, "R11", "strobes in reset",
              {ram_ce_n, ram_oe_n, ram_we_n, ram_lane_n}, 5'h1F);
        check(!ram_dq_oe && !rd_valid, "R11", "driver and valid in reset", {ram_dq_oe, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R11", "ready after reset", req_ready, 1);

        // Directed corner cases: address extremes, partial lanes, zero mask.
        do_write(2'b11, 18'h00000, 16'h1234);
        do_read (2'b11, 18'h00000);
        do_write(2'b11, 18'h3FFFF, 16'hBEEF);
        do_write(2'b01, 18'h3FFFF, 16'h55AA);           // R8 low lane only
        do_read (2'b11, 18'h3FFFF);
        do_write(2'b10, 18'h3FFFF, 16'hC3C3);           // R8 high lane only
        do_read (2'b11, 18'h3FFFF);
        do_read (2'b01, 18'h3FFFF);                     // R7 high lane zeroed
        do_read (2'b10, 18'h00000);                     // R7 low lane zeroed
        wait_idle();
        ce0 = ce_low_cnt;
        do_write(2'b00, 18'h00000, 16'hFFFF);           // R9 zero-mask write
        wait_idle();
        check(ce_low_cnt == ce0, "R9", "no chip-select for zero mask", ce_low_cnt, ce0);
        do_read (2'b11, 18'h00000);                     // R9 content unchanged
        do_read (2'b00, 18'h00000);
        wait_idle();
        check(ce_low_cnt == ce0 + RD, "R9", "zero-mask read skips RAM", ce_low_cnt, ce0 + RD);

        // Seeded random traffic over a small address pool.
        void'($urandom(32'h5EED_0001));
        foreach (pool[i]) pool[i] = AW'($urandom);
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] a = pool[$urandom_range(0, 11)];
            logic [1:0]    m = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1) do_write(m, a, DW'($urandom));
            else                           do_read(m, a);
        end
        wait_idle();

        check(contention == 0, "R5", "driver on while RAM outputs enabled", contention, 0);
        check(lane_bad == 0, "R6", "lane strobes match mask", lane_bad, 0);
        check(min_gap >= REC + 2, "R10", "idle gap between accesses", min_gap, REC + 2);
        check(ram_ce_n && !ram_dq_oe, "R4", "pins idle at end", {ram_ce_n, ram_dq_oe}, 2'b10);
        finish_run();
    end

endmodule